// File: doc/BRIEF.md
# Lock-Aware Translation Buffer

This block is a fully associative store of address translations. It has 64 slots, and each slot holds a 64-bit tag word and a 64-bit translation word. Bit 63 of the translation word marks the slot as valid. Bit 6 marks it as locked, or pinned. A single register-style request port reaches four spaces, chosen by a 2-bit selector:

- **Register bank.** Sixteen 64-bit registers, indexed by address bits [6:3].
- **Insert.** Places an entry using a replacement search.
- **Indexed slot access.** Writes or reads one slot, indexed by address bits [8:3].
- **Tag search.** Looks for a valid slot whose tag matches a key.

Every slot write takes its tag from register 6 of the bank, the tag-staging register. Software therefore loads that register first and then issues the write carrying the translation word. The replacement search is lock-aware:

1. An insert first fills the lowest-numbered slot that is not valid.
2. If every slot is valid, it fills the lowest-numbered slot that is not locked.
3. If every slot is both valid and locked, the insert is discarded and a one-cycle flag is raised.

Pinned translations therefore survive any number of ordinary inserts. Only the indexed port can overwrite them.

Top module: `tlb_xlate_buf`

## Requirements
- R1: After reset every slot's translation word reads 0 (not valid) and every bank register reads 0. A tag search in this state returns 0.
- R2: A write with selector 0 stores the write data in bank register address[6:3]. A read with selector 0 returns that register. Registers are independent of one another.
- R3: An insert (selector 1, write) fills the lowest-indexed slot whose translation word has bit 63 clear. This holds even when that slot has bit 6 set, or when an unlocked valid slot sits below it. The slot's tag becomes the current value of bank register 6.
- R4: When no slot is invalid, an insert fills the lowest-indexed slot with bit 6 clear. Locked slots keep their contents.
- R5: When all slots are valid and locked, an insert changes no slot. The output full_pulse is then high for exactly the one cycle after the request is accepted, and it is low after any other request.
- R6: An indexed write (selector 2, write) stores the write data as the translation word of slot address[8:3]. It also stores bank register 6 as that slot's tag, whether or not the slot was locked.
- R7: A tag search (selector 3, read, key on req_wdata) returns the tag of the lowest-indexed slot that is valid and whose tag equals the key. It returns 0 when no slot qualifies, including a slot with a matching tag that is not valid.
- R8: Every read request gives rsp_valid high with its data one cycle after acceptance. A write request gives rsp_valid low in that cycle. A write becomes visible to the very next request.
- R9: An indexed read (selector 2, read) returns the translation word of slot address[8:3].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | Space: 0 bank, 1 insert, 2 indexed slot, 3 tag search |
| req_addr | input | 16 | Word address; [6:3] picks a register, [8:3] picks a slot |
| req_wdata | input | 64 | Write data, or the search key |
| rsp_valid | output | 1 | Read data is present |
| rsp_rdata | output | 64 | Read data |
| full_pulse | output | 1 | An insert was dropped because every slot was pinned |

## Verification
The response is due one cycle after a request is accepted. This covers the read data, rsp_valid and full_pulse, because all three come from a single register stage. Slot and register updates made at the accepting edge are visible to the next request. The bench drives each request on a falling edge and lets it be accepted at the following rising edge. It then samples all outputs at the next falling edge, so every read and flag check sits exactly one cycle after its stimulus. Side-effect checks (evicted, kept or dropped entries) are made by later indexed reads and tag searches.

// File: rtl/tlb_xlate_pkg.sv
package tlb_xlate_pkg;

  localparam int XW        = 64;
  localparam int VALID_POS = 63;
  localparam int LOCK_POS  = 6;

  typedef enum logic [1:0] {
    SEL_BANK    = 2'd0,
    SEL_INSERT  = 2'd1,
    SEL_INDEXED = 2'd2,
    SEL_SEARCH  = 2'd3
  } tlb_sel_e;

  function automatic logic tte_is_valid(input logic [XW-1:0] tte);
    return tte[VALID_POS];
  endfunction

  function automatic logic tte_is_locked(input logic [XW-1:0] tte);
    return tte[LOCK_POS];
  endfunction

  // Extract an unsigned field of width w starting at bit lsb.
  function automatic logic [63:0] addr_field(input logic [63:0] a, input int lsb, input int w);
    logic [63:0] mask;
    mask = (64'd1 << w) - 64'd1;
    return (a >> lsb) & mask;
  endfunction

endpackage

// File: rtl/tlb_prio_pick.sv
module tlb_prio_pick #(
  parameter int N = 64,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/tlb_reg_bank.sv
module tlb_reg_bank #(
  parameter int NREGS   = 16,
  parameter int W       = 64,
  parameter int TAG_REG = 6,
  localparam int RW = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [RW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  output logic [W-1:0]  tag_word
);
  logic [W-1:0] regs_q [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      regs_q[wr_idx] <= wr_data;
    end
  end

  assign rd_data  = regs_q[rd_idx];
  assign tag_word = regs_q[TAG_REG];
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_xlate_pkg::*;
#(
  parameter int N = 64,
  parameter int W = 64,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_tag,
  input  logic [W-1:0]  wr_tte,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_tte,
  input  logic [W-1:0]  key,
  output logic          srch_hit,
  output logic [W-1:0]  srch_tag,
  output logic          free_any,
  output logic [IW-1:0] free_idx,
  output logic          evict_any,
  output logic [IW-1:0] evict_idx,
  output logic          all_pinned
);
  logic [W-1:0] tag_q [N];
  logic [W-1:0] tte_q [N];
  logic [N-1:0] valid_vec, lock_vec, hit_vec;
  logic [IW-1:0] hit_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        tag_q[i] <= '0;
        tte_q[i] <= '0;
      end
    end else if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      tte_q[wr_idx] <= wr_tte;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign valid_vec[g] = tte_is_valid(64'(tte_q[g]));
    assign lock_vec[g]  = tte_is_locked(64'(tte_q[g]));
    assign hit_vec[g]   = valid_vec[g] && (tag_q[g] == key);
  end

  tlb_prio_pick #(.N(N)) u_free  (.req(~valid_vec), .any(free_any),  .idx(free_idx));
  tlb_prio_pick #(.N(N)) u_evict (.req(~lock_vec),  .any(evict_any), .idx(evict_idx));
  tlb_prio_pick #(.N(N)) u_hit   (.req(hit_vec),    .any(srch_hit),  .idx(hit_idx));

  assign srch_tag   = srch_hit ? tag_q[hit_idx] : '0;
  assign rd_tte     = tte_q[rd_idx];
  assign all_pinned = &(valid_vec & lock_vec);
endmodule

// File: rtl/tlb_xlate_buf.sv
module tlb_xlate_buf
  import tlb_xlate_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int WORD_W  = 64,
  parameter int NREGS   = 16,
  parameter int ADDR_W  = 16,
  parameter int TAG_REG = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_sel,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              full_pulse
);
  localparam int SLOT_W    = $clog2(ENTRIES);
  localparam int REG_W     = $clog2(NREGS);
  localparam int FIELD_LSB = 3;

  logic [SLOT_W-1:0] slot_sel;
  logic [REG_W-1:0]  reg_sel;
  logic              bank_we, ins_fire, idx_fire, search_fire, ins_ok;
  logic              slot_we;
  logic [SLOT_W-1:0] slot_widx;
  logic [WORD_W-1:0] bank_rdata, tag_word, slot_rdata, search_tag;
  logic              search_hit, free_any, evict_any, all_pinned;
  logic [SLOT_W-1:0] free_idx, evict_idx;
  logic [WORD_W-1:0] rd_mux;

  logic              rsp_valid_q, full_q;
  logic [WORD_W-1:0] rsp_rdata_q;

  assign slot_sel = SLOT_W'(addr_field(64'(req_addr), FIELD_LSB, SLOT_W));
  assign reg_sel  = REG_W'(addr_field(64'(req_addr), FIELD_LSB, REG_W));

  assign bank_we     = req_valid &&  req_write && (req_sel == SEL_BANK);
  assign ins_fire    = req_valid &&  req_write && (req_sel == SEL_INSERT);
  assign idx_fire    = req_valid &&  req_write && (req_sel == SEL_INDEXED);
  assign search_fire = req_valid && !req_write && (req_sel == SEL_SEARCH);

  // Invalid slots first, then unlocked slots; nothing if all are pinned.
  assign ins_ok    = ins_fire && (free_any || evict_any);
  assign slot_we   = ins_ok || idx_fire;
  assign slot_widx = idx_fire ? slot_sel : (free_any ? free_idx : evict_idx);

  tlb_reg_bank #(
    .NREGS(NREGS), .W(WORD_W), .TAG_REG(TAG_REG)
  ) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(bank_we), .wr_idx(reg_sel), .wr_data(req_wdata),
    .rd_idx(reg_sel), .rd_data(bank_rdata), .tag_word(tag_word)
  );

  tlb_entry_store #(
    .N(ENTRIES), .W(WORD_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .wr_en(slot_we), .wr_idx(slot_widx), .wr_tag(tag_word), .wr_tte(req_wdata),
    .rd_idx(slot_sel), .rd_tte(slot_rdata),
    .key(req_wdata), .srch_hit(search_hit), .srch_tag(search_tag),
    .free_any(free_any), .free_idx(free_idx),
    .evict_any(evict_any), .evict_idx(evict_idx),
    .all_pinned(all_pinned)
  );

  always_comb begin
    case (req_sel)
      SEL_BANK:    rd_mux = bank_rdata;
      SEL_INDEXED: rd_mux = slot_rdata;
      SEL_SEARCH:  rd_mux = search_tag;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      full_q      <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid && !req_write;
      rsp_rdata_q <= (req_valid && !req_write) ? rd_mux : '0;
      full_q      <= ins_fire && !ins_ok;
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_rdata  = rsp_rdata_q;
  assign full_pulse = full_q;
endmodule

// File: rtl/tlb_xlate_buf_chk.sv
module tlb_xlate_buf_chk #(
  parameter int WORD_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic              rsp_valid,
  input logic [WORD_W-1:0] rsp_rdata,
  input logic              full_pulse,
  input logic              ins_fire,
  input logic              all_pinned,
  input logic              slot_we,
  input logic              search_fire,
  input logic              search_hit
);
  a_r8_read_answers: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid);

  a_r8_write_silent: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> !rsp_valid);

  a_r5_drop_flags: assert property (@(posedge clk) disable iff (rst)
    (ins_fire && all_pinned) |=> full_pulse);

  a_r5_drop_no_write: assert property (@(posedge clk) disable iff (rst)
    (ins_fire && all_pinned) |-> !slot_we);

  a_r5_flag_cause: assert property (@(posedge clk) disable iff (rst)
    full_pulse |-> $past(ins_fire));

  a_r7_miss_zero: assert property (@(posedge clk) disable iff (rst)
    (search_fire && !search_hit) |=> (rsp_rdata == '0));

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (!rsp_valid && !full_pulse));
endmodule

bind tlb_xlate_buf tlb_xlate_buf_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .full_pulse(full_pulse),
  .ins_fire(ins_fire), .all_pinned(all_pinned), .slot_we(slot_we),
  .search_fire(search_fire), .search_hit(search_hit)
);

// File: tb/tlb_xlate_buf_bench.sv
module tlb_xlate_buf_bench;
  localparam logic [63:0] V = 64'h8000_0000_0000_0000;
  localparam logic [63:0] L = 64'h0000_0000_0000_0040;
  localparam logic [15:0] TAGREG = 16'h0030;
  localparam logic [1:0] S_BANK = 2'd0, S_INS = 2'd1, S_IDX = 2'd2, S_SRCH = 2'd3;

  typedef struct packed {
    logic        wr;
    logic [1:0]  sel;
    logic [15:0] addr;
    logic [63:0] data;
    logic [63:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1, S_BANK, TAGREG,   64'hA000,       64'h0,          8'd2}, // R2 set tag-staging
    '{1'b0, S_BANK, TAGREG,   64'h0,          64'hA000,       8'd2}, // R2 read back
    '{1'b1, S_BANK, 16'h0010, 64'h1234,       64'h0,          8'd2}, // R2 reg 2
    '{1'b0, S_BANK, 16'h0010, 64'h0,          64'h1234,       8'd2}, // R2
    '{1'b0, S_BANK, TAGREG,   64'h0,          64'hA000,       8'd2}, // R2 independent
    '{1'b1, S_INS,  16'h0,    V | 64'h11,     64'h0,          8'd3}, // R3 -> slot 0
    '{1'b0, S_IDX,  16'h0000, 64'h0,          V | 64'h11,     8'd9}, // R9 slot 0
    '{1'b0, S_SRCH, 16'h0,    64'hA000,       64'hA000,       8'd7}, // R7 hit
    '{1'b1, S_BANK, TAGREG,   64'hB000,       64'h0,          8'd3}, // R3
    '{1'b1, S_INS,  16'h0,    V | 64'h22,     64'h0,          8'd3}, // R3 -> slot 1
    '{1'b0, S_IDX,  16'h0008, 64'h0,          V | 64'h22,     8'd3}, // R3 slot 1
    '{1'b0, S_SRCH, 16'h0,    64'hB000,       64'hB000,       8'd7}, // R7 hit
    '{1'b0, S_SRCH, 16'h0,    64'hC000,       64'h0,          8'd7}  // R7 miss
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_sel = 2'd0;
  logic [15:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid, full_pulse;
  logic [63:0] rsp_rdata;

  int checks = 0, errors = 0;
  logic done = 1'b0;
  logic last_full;
  logic [63:0] got;

  always #5 clk = ~clk;

  tlb_xlate_buf u_tlb_xlate_buf (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_sel(req_sel), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .full_pulse(full_pulse)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Each op starts just after a falling edge and returns after the next one.
  task automatic op(input logic wr, input logic [1:0] sel, input logic [15:0] addr,
                    input logic [63:0] data, output logic [63:0] rdata);
    req_valid = 1'b1; req_write = wr; req_sel = sel; req_addr = addr; req_wdata = data;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rdata = rsp_rdata;
    last_full = full_pulse;
    check("R8 rsp_valid", {63'd0, rsp_valid}, {63'd0, !wr});
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] addr, input logic [63:0] data);
    logic [63:0] d;
    op(1'b1, sel, addr, data, d);
  endtask

  task automatic rd(input logic [1:0] sel, input logic [15:0] addr, input logic [63:0] key,
                    output logic [63:0] rdata);
    op(1'b0, sel, addr, key, rdata);
  endtask

  function automatic logic [15:0] slot_addr(input int s);
    return 16'(s << 3);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 rsp_valid idle", {63'd0, rsp_valid}, 64'd0);
    rd(S_IDX, slot_addr(0), 64'h0, got);  check("R1 slot0", got, 64'h0);
    rd(S_IDX, slot_addr(63), 64'h0, got); check("R1 slot63", got, 64'h0);
    rd(S_SRCH, 16'h0, 64'h0, got);        check("R1 search", got, 64'h0);
    rd(S_BANK, TAGREG, 64'h0, got);       check("R1 reg6", got, 64'h0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].sel, VEC[i].addr, VEC[i].data);
      else begin
        rd(VEC[i].sel, VEC[i].addr, VEC[i].data, got);
        check($sformatf("R%0d vector %0d", VEC[i].req, i), got, VEC[i].exp);
      end
    end

    // R4: all valid, slots 0..9 locked
    for (int i = 0; i < 64; i++) begin
      wr(S_BANK, TAGREG, 64'h1000 + 64'(i));
      wr(S_IDX, slot_addr(i), V | ((i < 10) ? L : 64'h0) | (64'(i) << 8));
    end
    wr(S_BANK, TAGREG, 64'h7777);
    wr(S_INS, 16'h0, V | 64'hAA00);
    check("R5 no flag on normal insert", {63'd0, last_full}, 64'd0);
    rd(S_IDX, slot_addr(10), 64'h0, got); check("R4 first unlocked slot", got, V | 64'hAA00);
    rd(S_IDX, slot_addr(9), 64'h0, got);  check("R4 locked kept", got, V | L | (64'd9 << 8));
    rd(S_SRCH, 16'h0, 64'h7777, got);     check("R4 new tag", got, 64'h7777);
    rd(S_SRCH, 16'h0, 64'h100A, got);     check("R4 evicted tag", got, 64'h0);

    // R3: invalid slot preferred over lower unlocked valid slot
    wr(S_IDX, slot_addr(20), 64'h0);
    wr(S_BANK, TAGREG, 64'h8888);
    wr(S_INS, 16'h0, V | 64'hBB00);
    rd(S_IDX, slot_addr(20), 64'h0, got); check("R3 invalid first", got, V | 64'hBB00);
    rd(S_IDX, slot_addr(11), 64'h0, got); check("R3 unlocked kept", got, V | (64'd11 << 8));

    // R7: invalid entry with matching tag does not hit
    wr(S_BANK, TAGREG, 64'hDEAD);
    wr(S_IDX, slot_addr(30), L);
    rd(S_SRCH, 16'h0, 64'hDEAD, got); check("R7 invalid no hit", got, 64'h0);
    rd(S_SRCH, 16'h0, 64'h101F, got); check("R7 slot31 hit", got, 64'h101F);

    // R3: invalid but locked slot is still taken first
    wr(S_BANK, TAGREG, 64'h9999);
    wr(S_INS, 16'h0, V | 64'hCC00);
    rd(S_IDX, slot_addr(30), 64'h0, got); check("R3 invalid locked slot", got, V | 64'hCC00);

    // R6/R5: pin every slot with the indexed port
    for (int i = 0; i < 64; i++) begin
      wr(S_BANK, TAGREG, 64'h2000 + 64'(i));
      wr(S_IDX, slot_addr(i), V | L | (64'(i) << 8));
    end
    rd(S_IDX, slot_addr(5), 64'h0, got); check("R6 overwrite locked", got, V | L | (64'd5 << 8));
    rd(S_SRCH, 16'h0, 64'h2005, got);    check("R6 tag from reg6", got, 64'h2005);
    wr(S_BANK, TAGREG, 64'h5555);
    wr(S_INS, 16'h0, V | 64'hDD00);
    check("R5 full pulse", {63'd0, last_full}, 64'd1);
    rd(S_IDX, slot_addr(0), 64'h0, got);
    check("R5 pulse one cycle", {63'd0, last_full}, 64'd0);
    check("R5 slot0 untouched", got, V | L);
    rd(S_SRCH, 16'h0, 64'h5555, got); check("R5 dropped", got, 64'h0);
    rd(S_SRCH, 16'h0, 64'h203F, got); check("R7 slot63 hit", got, 64'h203F);

    // R2: highest register index
    wr(S_BANK, 16'h0078, 64'hFEED);
    rd(S_BANK, 16'h0078, 64'h0, got); check("R2 reg15", got, 64'hFEED);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule